// File: doc/BRIEF.md
# Restartable Watchdog Pulse Timer

This block measures a programmable interval by counting a slow tick enable, nominally 32.768 kHz, and emits a short pulse on its timer output each time the interval runs out. The pulse repeats with the chosen period for as long as the timer runs. Software picks the interval with a 3-bit code, and code zero halts the timer.

A one-cycle restart strobe returns the interval counter to zero, so the block works as a watchdog. Firmware that restarts it often enough never sees a pulse. The same strobe cuts short any pulse in progress and clears a sticky timer flag. That flag rises whenever a pulse begins.

A chip-enable input freezes all counting while it is low. A one-cycle oscillation-stop indication clears the timer enable bit, and the output stays quiet until software writes the enable bit back to 1. Register access is reduced to write strobes with data. The current settings are visible on outputs.

Top module: `wdt_pulse_timer`

## Requirements
- R1: After reset, pulse_o, flag_o and enable_o are 0 and sel_o is 0.
- R2: The interval is N seconds of ticks (N × TICKS_PER_SEC). The sel code maps to N as follows: 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→60. After a restart strobe, or after the timer starts from halt, pulse_o rises on the N × TICKS_PER_SEC-th counted tick.
- R3: Each pulse stays high for exactly PULSE_TICKS counted ticks. Successive rising edges are one interval apart.
- R4: Restart strobes issued before expiry prevent any pulse. A restart strobe in the same cycle as the expiring tick wins: no pulse starts and the interval begins again.
- R5: A restart strobe while pulse_o is high drives pulse_o low on the next clock.
- R6: A cycle with chip_en low or tick_en low does not advance the counter. Counting resumes from the held value once both are high again.
- R7: An oscillation-stop indication clears enable_o on the next clock, forces pulse_o low and blocks pulses. It overrides an enable write in the same cycle. Writing the enable bit to 1 afterwards starts a fresh interval from zero.
- R8: Code 0 halts the timer: pulse_o stays low and the count returns to zero. Writing a nonzero code then starts a full interval.
- R9: flag_o sets when a pulse starts, stays set after the pulse ends, and clears on a restart strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow-tick enable, one cycle per tick |
| chip_en | input | 1 | Counting allowed when high |
| sel_wr | input | 1 | Write strobe for the interval code |
| sel_wdata | input | 3 | Interval code to write |
| en_wr | input | 1 | Write strobe for the timer enable bit |
| en_wdata | input | 1 | Enable value to write |
| restart_wr | input | 1 | Strobe for writing 1 to the restart bit |
| osc_stop | input | 1 | Oscillation-stop indication, one cycle |
| sel_o | output | 3 | Current interval code |
| enable_o | output | 1 | Current timer enable bit |
| flag_o | output | 1 | Timer flag |
| pulse_o | output | 1 | Timer output pulse |

## Verification
A restart strobe and the expiring tick can land in the same cycle, so the bench counts down to the tick just before expiry and raises the restart strobe there. It then expects pulse_o and flag_o to stay low and the next pulse to come a full interval later. A second collision puts an oscillation-stop indication and an enable write of 1 in the same cycle, and the enable bit must read 0 afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    SEL_HALT = 3'd0,
    SEL_1S   = 3'd1,
    SEL_2S   = 3'd2,
    SEL_4S   = 3'd3,
    SEL_8S   = 3'd4,
    SEL_16S  = 3'd5,
    SEL_32S  = 3'd6,
    SEL_60S  = 3'd7
  } wdt_sel_e;

  // seconds per interval code; zero means halted
  function automatic int unsigned interval_sec(input logic [2:0] code);
    case (wdt_sel_e'(code))
      SEL_1S:  return 1;
      SEL_2S:  return 2;
      SEL_4S:  return 4;
      SEL_8S:  return 8;
      SEL_16S: return 16;
      SEL_32S: return 32;
      SEL_60S: return 60;
      default: return 0;
    endcase
  endfunction

  // last count value before expiry for a given code
  function automatic int unsigned last_count(input logic [2:0] code,
                                             input int unsigned tps);
    return interval_sec(code) * tps - 1;
  endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [2:0] sel_wdata,
  input  logic       en_wr,
  input  logic       en_wdata,
  input  logic       osc_stop,
  input  logic       restart_wr,
  input  logic       start_evt,
  output logic [2:0] sel_q,
  output logic       en_q,
  output logic       flag_q,
  output logic       run_q,
  output logic       halt_nxt
);
  logic [2:0] sel_d;
  logic       en_d;

  always_comb begin
    sel_d = sel_wr ? sel_wdata : sel_q;
    if (osc_stop)   en_d = 1'b0;
    else if (en_wr) en_d = en_wdata;
    else            en_d = en_q;
  end

  assign halt_nxt = !(en_d && (sel_d != 3'd0));
  assign run_q    = en_q && (sel_q != 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 3'd0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
      if (restart_wr)     flag_q <= 1'b0;
      else if (start_evt) flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_interval_cnt.sv
module wdt_interval_cnt #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  localparam int unsigned CNT_W = $clog2(60 * TICKS_PER_SEC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       run_q,
  input  logic       halt_nxt,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       expire
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             clear;
  logic             step;

  assign lim_m1 = CNT_W'(last_count(sel, TICKS_PER_SEC));
  assign clear  = halt_nxt || restart;
  assign step   = run_q && adv && !clear;
  assign expire = step && (cnt >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (step)    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 8,
  localparam int unsigned PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic start,
  input  logic kill,
  output logic pulse
);
  logic [PW-1:0] pc;
  logic          last_tick;

  assign last_tick = (pc == PW'(PULSE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      pc    <= '0;
    end else if (kill) begin
      pulse <= 1'b0;
      pc    <= '0;
    end else if (start) begin
      pulse <= 1'b1;
      pc    <= '0;
    end else if (pulse && adv) begin
      if (last_tick) begin
        pulse <= 1'b0;
        pc    <= '0;
      end else begin
        pc <= pc + PW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned PULSE_TICKS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       chip_en,
  input  logic       sel_wr,
  input  logic [2:0] sel_wdata,
  input  logic       en_wr,
  input  logic       en_wdata,
  input  logic       restart_wr,
  input  logic       osc_stop,
  output logic [2:0] sel_o,
  output logic       enable_o,
  output logic       flag_o,
  output logic       pulse_o
);
  logic adv;
  logic run_q;
  logic halt_nxt;
  logic expire_evt;

  assign adv = tick_en && chip_en;

  wdt_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .osc_stop  (osc_stop),
    .restart_wr(restart_wr),
    .start_evt (expire_evt),
    .sel_q     (sel_o),
    .en_q      (enable_o),
    .flag_q    (flag_o),
    .run_q     (run_q),
    .halt_nxt  (halt_nxt)
  );

  wdt_interval_cnt #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .run_q   (run_q),
    .halt_nxt(halt_nxt),
    .restart (restart_wr),
    .sel     (sel_o),
    .expire  (expire_evt)
  );

  wdt_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (adv),
    .start(expire_evt),
    .kill (restart_wr || halt_nxt),
    .pulse(pulse_o)
  );
endmodule

// File: rtl/wdt_pulse_timer_chk.sv
module wdt_pulse_timer_chk #(
  parameter int unsigned PULSE_TICKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       chip_en,
  input logic       sel_wr,
  input logic       en_wr,
  input logic       restart_wr,
  input logic       osc_stop,
  input logic [2:0] sel_o,
  input logic       enable_o,
  input logic       flag_o,
  input logic       pulse_o,
  input logic       expire_evt
);
  int unsigned wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wcnt <= 0;
    else if (!pulse_o || expire_evt) wcnt <= 0;
    else if (tick_en && chip_en)  wcnt <= wcnt + 1;
  end

  AST_EXPIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (pulse_o && flag_o)); // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (wcnt < PULSE_TICKS)); // R3

  AST_RESTART_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr |=> (!pulse_o && !flag_o)); // R5

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !restart_wr && !osc_stop && !en_wr && !sel_wr) |=> $stable(pulse_o)); // R6

  AST_OSC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> (!enable_o && !pulse_o)); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_o || sel_o == 3'd0) |-> !pulse_o); // R8

  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> flag_o); // R9
endmodule

bind wdt_pulse_timer wdt_pulse_timer_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .chip_en   (chip_en),
  .sel_wr    (sel_wr),
  .en_wr     (en_wr),
  .restart_wr(restart_wr),
  .osc_stop  (osc_stop),
  .sel_o     (sel_o),
  .enable_o  (enable_o),
  .flag_o    (flag_o),
  .pulse_o   (pulse_o),
  .expire_evt(expire_evt)
);

// File: tb/wdt_pulse_timer_tb.sv
module wdt_pulse_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 16;
  localparam int PULSE      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       chip_en = 1'b1;
  logic       sel_wr = 1'b0;
  logic [2:0] sel_wdata = 3'd0;
  logic       en_wr = 1'b0;
  logic       en_wdata = 1'b0;
  logic       restart_wr = 1'b0;
  logic       osc_stop = 1'b0;
  logic [2:0] sel_o;
  logic       enable_o, flag_o, pulse_o;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_pulse_timer #(.TICKS_PER_SEC(TPS), .PULSE_TICKS(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chip_en(chip_en),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .restart_wr(restart_wr), .osc_stop(osc_stop), .sel_o(sel_o),
    .enable_o(enable_o), .flag_o(flag_o), .pulse_o(pulse_o)
  );

  function automatic int exp_limit(input int code);
    if (code == 0) return 0;
    if (code == 7) return 60 * TPS;
    return TPS << (code - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // optional code write together with a restart strobe
  task automatic cfg(input bit wr_sel, input int code);
    @(negedge clk);
    sel_wr = wr_sel; sel_wdata = 3'(code); restart_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0; restart_wr = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pulse_o) begin n = i + 1; break; end
    end
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulse_o) seen++;
    end
  endtask

  task automatic t_reset;
    chk(pulse_o == 0, "R1 pulse", pulse_o, 0);
    chk(flag_o == 0, "R1 flag", flag_o, 0);
    chk(enable_o == 0, "R1 enable", enable_o, 0);
    chk(sel_o == 0, "R1 sel", sel_o, 0);
  endtask

  task automatic t_intervals;
    int n, w, p;
    bit prev, flag_gap;
    @(negedge clk); en_wr = 1'b1; en_wdata = 1'b1;
    @(negedge clk); en_wr = 1'b0;
    for (int code = 1; code < 8; code++) begin
      cfg(1'b1, code);
      wait_rise(n);
      chk(n == exp_limit(code), "R2 interval", n, exp_limit(code));
    end
    cfg(1'b1, 1);
    wait_rise(n);
    chk(flag_o == 1, "R9 flag on start", flag_o, 1);
    w = 1; p = 0; prev = 1'b1; flag_gap = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      p++;
      if (pulse_o && !prev) break;
      if (pulse_o) w++;
      if (!pulse_o && prev) flag_gap = flag_o;
      prev = pulse_o;
    end
    chk(w == PULSE, "R3 width", w, PULSE);
    chk(p == exp_limit(1), "R3 period", p, exp_limit(1));
    chk(flag_gap == 1, "R9 flag held", flag_gap, 1);
  endtask

  task automatic t_kicks;
    int seen, s, n;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      cfg(1'b0, 0);
      quiet(12, s);
      seen += s;
    end
    chk(seen == 0, "R4 kicks prevent pulse", seen, 0);
    cfg(1'b0, 0);
    quiet(exp_limit(1) - 1, s);
    chk(s == 0, "R4 before expiry", s, 0);
    restart_wr = 1'b1;  // collides with the expiring tick
    @(negedge clk);
    restart_wr = 1'b0;
    chk(pulse_o == 0, "R4 restart wins pulse", pulse_o, 0);
    chk(flag_o == 0, "R4 restart wins flag", flag_o, 0);
    wait_rise(n);
    chk(n == exp_limit(1), "R4 fresh interval", n, exp_limit(1));
  endtask

  task automatic t_cancel;
    repeat (3) @(negedge clk);
    chk(pulse_o == 1, "R5 pulse active", pulse_o, 1);
    restart_wr = 1'b1;
    @(negedge clk);
    restart_wr = 1'b0;
    chk(pulse_o == 0, "R5 pulse cut", pulse_o, 0);
    chk(flag_o == 0, "R9 flag cleared", flag_o, 0);
  endtask

  task automatic t_freeze;
    int s, n;
    cfg(1'b0, 0);
    repeat (5) @(negedge clk);
    chip_en = 1'b0;
    quiet(20, s);
    chip_en = 1'b1;
    wait_rise(n);
    chk(s == 0, "R6 chip_en low quiet", s, 0);
    chk(n == exp_limit(1) - 5, "R6 resume chip_en", n, exp_limit(1) - 5);
    cfg(1'b0, 0);
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    quiet(10, s);
    tick_en = 1'b1;
    wait_rise(n);
    chk(n == exp_limit(1) - 5, "R6 resume tick_en", n, exp_limit(1) - 5);
  endtask

  task automatic t_osc;
    int s, n;
    @(negedge clk); osc_stop = 1'b1;
    @(negedge clk); osc_stop = 1'b0;
    chk(enable_o == 0, "R7 enable cleared", enable_o, 0);
    chk(pulse_o == 0, "R7 pulse off", pulse_o, 0);
    quiet(3 * exp_limit(1), s);
    chk(s == 0, "R7 no pulses", s, 0);
    @(negedge clk); osc_stop = 1'b1; en_wr = 1'b1; en_wdata = 1'b1;
    @(negedge clk); osc_stop = 1'b0; en_wr = 1'b0;
    chk(enable_o == 0, "R7 stop beats write", enable_o, 0);
    @(negedge clk); en_wr = 1'b1; en_wdata = 1'b1;
    @(negedge clk); en_wr = 1'b0;
    chk(enable_o == 1, "R7 re-enabled", enable_o, 1);
    wait_rise(n);
    chk(n == exp_limit(1), "R7 fresh interval", n, exp_limit(1));
  endtask

  task automatic t_halt;
    int s, n;
    cfg(1'b0, 0);
    repeat (6) @(negedge clk);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = 3'd0;
    @(negedge clk); sel_wr = 1'b0;
    chk(sel_o == 0, "R8 code zero", sel_o, 0);
    quiet(3 * exp_limit(1), s);
    chk(s == 0, "R8 halted quiet", s, 0);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = 3'd1;
    @(negedge clk); sel_wr = 1'b0;
    wait_rise(n);
    chk(n == exp_limit(1), "R8 full interval", n, exp_limit(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_intervals();
    t_kicks();
    t_cancel();
    t_freeze();
    t_osc();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule